// File: doc/BRIEF.md
# GF(4) Layered Min-Max Variable Node Unit

This block does the variable-node arithmetic of a layered min-max decoder for a column-weight-3 non-binary LDPC code over GF(4). For one variable node it takes two things. The first is the channel reliability vector, one signed metric for each of the four field elements. The second is the check-to-variable vectors that the three layers the node belongs to have stored. From these it forms the a-posteriori vector, picks the cheapest field element as a tentative hard decision for early termination, and builds the outgoing variable-to-check vector for the layer being processed. That vector leaves out the current layer's own message and is shifted so that its smallest entry is zero.

The channel vector is never updated by the block. Each time a layer is processed, the caller presents the same channel metrics again, together with the refreshed per-layer check messages. Both the input and the output are valid/ready streams, and the block takes one variable node per cycle through a single registered stage. A result that has been accepted stays on the output, unchanged, until the consumer takes it. The input is ready whenever the output register is empty or is being drained in that cycle, so a stalled consumer blocks new input after exactly one result.

In the flat vectors, field element a sits at bit offset a·W of its group. Layer l of the check input occupies the a-th word of group l.

Top module: `lmm_vnu`

## Requirements
- R1: For every field element a, out_total[a] (8-bit signed) equals chan[a] + c2v[0][a] + c2v[1][a] + c2v[2][a], where all inputs are 6-bit two's complement and element a is word a of each vector. The sum is exact, with no wrap and no clipping.
- R2: When in_layer is 0, 1 or 2, the unnormalized extrinsic value for element a is chan[a] plus the check messages of the two layers other than in_layer.
- R3: out_v2c[a] equals the extrinsic value of element a minus the smallest extrinsic value over all four elements, so at least one entry of a valid output is zero.
- R4: A normalized value above 31 is clipped to 31, so out_v2c entries always lie in 0..31.
- R5: out_dec is the index (0..3) of the element with the smallest out_total. When several elements tie, the lowest index wins.
- R6: When in_layer is 3, no layer is excluded, and out_v2c is the normalized a-posteriori vector.
- R7: An input accepted at a clock edge (in_valid and in_ready both high) appears on the outputs with out_valid high right after that same edge. out_valid is low when nothing is held.
- R8: While out_valid is high and out_ready is low, the outputs hold steady and in_ready is low. At all other times in_ready is high.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vectors are valid |
| in_ready | output | 1 | Block can take an input this cycle |
| in_layer | input | 2 | Layer being processed; 3 means exclude none |
| in_chan | input | 24 | Channel metrics, four 6-bit signed words |
| in_c2v | input | 72 | Check messages, three layers of four 6-bit signed words |
| out_valid | output | 1 | Output result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_v2c | output | 24 | Normalized variable-to-check vector, four 6-bit words |
| out_total | output | 32 | A-posteriori vector, four 8-bit signed words |
| out_dec | output | 2 | Tentative symbol decision |

## Verification
The bench aims at the widest spread of extrinsic values. It drives one element at the most negative input on every layer and another at the most positive, which yields a difference of 189. A design without a guard bit in the subtraction would wrap that difference to a small or negative value instead of clipping it to 31. Ties for the minimum, both among all four elements and between the two highest indices, expose a comparator that lets a later element win on equality. Layer select 3, together with each of the other select values, catches exclusion logic that decodes the select loosely. Random back-pressure on the output exposes a stage that overwrites or drops a held result, or that raises ready while stalled.

// File: rtl/vnu_pkg.sv
package vnu_pkg;
  parameter int GF_Q       = 4;   // field size
  parameter int NUM_LAYERS = 3;   // column weight
  parameter int MSG_W      = 6;   // message word, sign included
  parameter int SUM_W      = 8;   // accumulation width
  localparam int SYM_W  = $clog2(GF_Q);
  localparam int LSEL_W = $clog2(NUM_LAYERS + 1);
endpackage

// File: rtl/vnu_accum.sv
module vnu_accum #(
  parameter int Q   = 4,
  parameter int L   = 3,
  parameter int MW  = 6,
  parameter int SW  = 8,
  parameter int LSW = 2
) (
  input  logic [Q*MW-1:0]   chan_i,
  input  logic [L*Q*MW-1:0] c2v_i,
  input  logic [LSW-1:0]    sel_i,
  output logic [Q*SW-1:0]   total_o,
  output logic [Q*SW-1:0]   extr_o
);
  for (genvar a = 0; a < Q; a++) begin : g_elem
    logic signed [SW-1:0] acc;
    logic signed [SW-1:0] exc;
    always_comb begin
      acc = SW'($signed(chan_i[a*MW +: MW]));
      exc = acc;
      for (int l = 0; l < L; l++) begin
        acc = acc + SW'($signed(c2v_i[(l*Q+a)*MW +: MW]));
        if (l != int'(sel_i))
          exc = exc + SW'($signed(c2v_i[(l*Q+a)*MW +: MW]));
      end
    end
    assign total_o[a*SW +: SW] = acc;
    assign extr_o[a*SW +: SW]  = exc;
  end
endmodule

// File: rtl/vnu_norm.sv
module vnu_norm #(
  parameter int Q  = 4,
  parameter int MW = 6,
  parameter int SW = 8
) (
  input  logic [Q*SW-1:0] extr_i,
  output logic [Q*MW-1:0] v2c_o
);
  localparam int MAXP = (1 << (MW - 1)) - 1;

  logic signed [SW-1:0] mn;
  always_comb begin
    mn = $signed(extr_i[SW-1:0]);
    for (int a = 1; a < Q; a++)
      if ($signed(extr_i[a*SW +: SW]) < mn) mn = $signed(extr_i[a*SW +: SW]);
  end

  for (genvar a = 0; a < Q; a++) begin : g_sub
    logic signed [SW:0] d;
    always_comb begin
      d = $signed({extr_i[a*SW+SW-1], extr_i[a*SW +: SW]}) - $signed({mn[SW-1], mn});
      if (int'(d) > MAXP) v2c_o[a*MW +: MW] = MW'(MAXP);
      else                v2c_o[a*MW +: MW] = d[MW-1:0];
    end
  end
endmodule

// File: rtl/vnu_argmin.sv
module vnu_argmin #(
  parameter int Q   = 4,
  parameter int SW  = 8,
  parameter int SYW = 2
) (
  input  logic [Q*SW-1:0] total_i,
  output logic [SYW-1:0]  dec_o
);
  always_comb begin
    dec_o = '0;
    for (int a = 1; a < Q; a++)
      if ($signed(total_i[a*SW +: SW]) < $signed(total_i[int'(dec_o)*SW +: SW]))
        dec_o = SYW'(a);
  end
endmodule

// File: rtl/lmm_vnu.sv
module lmm_vnu #(
  parameter int GF_Q       = vnu_pkg::GF_Q,
  parameter int NUM_LAYERS = vnu_pkg::NUM_LAYERS,
  parameter int MSG_W      = vnu_pkg::MSG_W,
  parameter int SUM_W      = vnu_pkg::SUM_W,
  localparam int SYM_W  = $clog2(GF_Q),
  localparam int LSEL_W = $clog2(NUM_LAYERS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LSEL_W-1:0]             in_layer,
  input  logic [GF_Q*MSG_W-1:0]         in_chan,
  input  logic [NUM_LAYERS*GF_Q*MSG_W-1:0] in_c2v,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [GF_Q*MSG_W-1:0]         out_v2c,
  output logic [GF_Q*SUM_W-1:0]         out_total,
  output logic [SYM_W-1:0]              out_dec
);
  logic [GF_Q*SUM_W-1:0] total_c, extr_c;
  logic [GF_Q*MSG_W-1:0] v2c_c;
  logic [SYM_W-1:0]      dec_c;

  vnu_accum #(.Q(GF_Q), .L(NUM_LAYERS), .MW(MSG_W), .SW(SUM_W), .LSW(LSEL_W)) u_accum (
    .chan_i(in_chan), .c2v_i(in_c2v), .sel_i(in_layer),
    .total_o(total_c), .extr_o(extr_c));

  vnu_norm #(.Q(GF_Q), .MW(MSG_W), .SW(SUM_W)) u_norm (
    .extr_i(extr_c), .v2c_o(v2c_c));

  vnu_argmin #(.Q(GF_Q), .SW(SUM_W), .SYW(SYM_W)) u_argmin (
    .total_i(total_c), .dec_o(dec_c));

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_v2c   <= '0;
      out_total <= '0;
      out_dec   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_v2c   <= v2c_c;
        out_total <= total_c;
        out_dec   <= dec_c;
      end
    end
  end
endmodule

// File: rtl/vnu_chk.sv
module vnu_chk #(
  parameter int GF_Q       = 4,
  parameter int NUM_LAYERS = 3,
  parameter int MSG_W      = 6,
  parameter int SUM_W      = 8,
  localparam int SYM_W  = $clog2(GF_Q),
  localparam int LSEL_W = $clog2(NUM_LAYERS + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic [LSEL_W-1:0]             in_layer,
  input logic [GF_Q*MSG_W-1:0]         in_chan,
  input logic [NUM_LAYERS*GF_Q*MSG_W-1:0] in_c2v,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [GF_Q*MSG_W-1:0]         out_v2c,
  input logic [GF_Q*SUM_W-1:0]         out_total,
  input logic [SYM_W-1:0]              out_dec
);
  logic zero_seen, neg_seen, dec_ok;
  always_comb begin
    zero_seen = 1'b0;
    neg_seen  = 1'b0;
    dec_ok    = 1'b1;
    for (int a = 0; a < GF_Q; a++) begin
      if (out_v2c[a*MSG_W +: MSG_W] == '0) zero_seen = 1'b1;
      if (out_v2c[a*MSG_W + MSG_W - 1])    neg_seen  = 1'b1;
      if ($signed(out_total[a*SUM_W +: SUM_W]) < $signed(out_total[int'(out_dec)*SUM_W +: SUM_W]))
        dec_ok = 1'b0;
      if (a < int'(out_dec) &&
          $signed(out_total[a*SUM_W +: SUM_W]) == $signed(out_total[int'(out_dec)*SUM_W +: SUM_W]))
        dec_ok = 1'b0;
    end
  end

  // R7
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R7
  idle_stays_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !out_valid |=> !out_valid);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_v2c) && $stable(out_total) && $stable(out_dec));
  // R8
  stall_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R3
  min_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> zero_seen);
  // R4
  v2c_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !neg_seen);
  // R5
  dec_is_argmin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> dec_ok);
endmodule

bind lmm_vnu vnu_chk #(.GF_Q(GF_Q), .NUM_LAYERS(NUM_LAYERS), .MSG_W(MSG_W), .SUM_W(SUM_W)) i_chk (.*);

// File: tb/test_lmm_vnu.sv
module test_lmm_vnu;
  localparam int Q = 4, L = 3, MW = 6, SW = 8, SYW = 2, LSW = 2;
  localparam int OW = Q*MW + Q*SW + SYW;

  logic clk, rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [LSW-1:0]    in_layer;
  logic [Q*MW-1:0]   in_chan, out_v2c;
  logic [L*Q*MW-1:0] in_c2v;
  logic [Q*SW-1:0]   out_total;
  logic [SYW-1:0]    out_dec;

  int checks = 0, errors = 0;
  logic [OW-1:0] exp_q[$];

  lmm_vnu i_lmm_vnu (.*);

  // 200 MHz, time unit 1 ps
  initial clk = 1'b0;
  always #2500 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [OW-1:0] ref_model(logic [Q*MW-1:0] ch, logic [L*Q*MW-1:0] cv, logic [LSW-1:0] sel);
    int tot[Q];
    int ext[Q];
    int mn, best, d;
    logic [Q*MW-1:0] v;
    logic [Q*SW-1:0] t;
    for (int a = 0; a < Q; a++) begin
      tot[a] = int'($signed(ch[a*MW +: MW]));
      ext[a] = tot[a];
      for (int l = 0; l < L; l++) begin
        int c;
        c = int'($signed(cv[(l*Q+a)*MW +: MW]));
        tot[a] += c;
        if (l != int'(sel)) ext[a] += c;
      end
    end
    mn = ext[0];
    for (int a = 1; a < Q; a++) if (ext[a] < mn) mn = ext[a];
    best = 0;
    for (int a = 0; a < Q; a++) begin
      d = ext[a] - mn;
      if (d > 31) d = 31;
      v[a*MW +: MW] = MW'(d);
      t[a*SW +: SW] = SW'(tot[a]);
      if (tot[a] < tot[best]) best = a;
    end
    return {v, t, SYW'(best)};
  endfunction

  function automatic logic [Q*MW-1:0] fill(int e0, int e1, int e2, int e3);
    return {MW'(e3), MW'(e2), MW'(e1), MW'(e0)};
  endfunction

  // compare outputs at the falling edge, then record handshakes before the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == (exp_q.size() != 0), "R7", 64'(out_valid), 64'(exp_q.size() != 0));
      if (out_valid && exp_q.size() != 0) begin
        logic [OW-1:0] e;
        e = exp_q[0];
        chk(out_total == e[SYW +: Q*SW], "R1", 64'(out_total), 64'(e[SYW +: Q*SW]));
        chk(out_v2c == e[SYW+Q*SW +: Q*MW], "R2 R3 R4 R6", 64'(out_v2c), 64'(e[SYW+Q*SW +: Q*MW]));
        chk(out_dec == e[SYW-1:0], "R5", 64'(out_dec), 64'(e[SYW-1:0]));
      end
      #1500;
      chk(in_ready == (!out_valid || out_ready), "R8", 64'(in_ready), 64'(!out_valid || out_ready));
      if (out_valid && out_ready && exp_q.size() != 0) void'(exp_q.pop_front());
      if (in_valid && in_ready) exp_q.push_back(ref_model(in_chan, in_c2v, in_layer));
    end
  end

  task automatic send(input logic [Q*MW-1:0] ch, input logic [L*Q*MW-1:0] cv, input logic [LSW-1:0] sel);
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk); #500;
      in_valid  = 1'b1;
      in_chan   = ch;
      in_c2v    = cv;
      in_layer  = sel;
      out_ready = ($urandom_range(0, 3) != 0);
      #1000;
      done = in_ready;
    end
  endtask

  task automatic idle(input bit rdy);
    @(negedge clk); #500;
    in_valid  = 1'b0;
    out_ready = rdy;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_layer = '0; in_chan = '0; in_c2v = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #100;
    // R9
    chk(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R9", 64'(in_ready), 64'd1);

    // R5: all-zero input, four-way tie resolves to element 0
    send('0, '0, 2'd0);
    // R4: spread of 189 between elements 0 and 1 clips to 31
    send(fill(-32, 31, 0, 0), {3{fill(-32, 31, 0, 0)}}, 2'd0);
    send(fill(-32, 31, 0, 0), {3{fill(-32, 31, 0, 0)}}, 2'd3);
    // R5: tie between elements 2 and 3 resolves to 2
    send(fill(5, 5, -3, -3), '0, 2'd1);
    // R6: select 3 keeps every layer
    send(fill(1, 2, 3, 4), {fill(0, 0, 0, 9), fill(0, 3, 0, 0), fill(-7, 0, 0, 0)}, 2'd3);
    // R2: each select drops a distinct layer
    for (int s = 0; s < 3; s++)
      send(fill(1, 2, 3, 4), {fill(0, 0, 0, 9), fill(0, 3, 0, 0), fill(-7, 0, 0, 0)}, LSW'(s));
    // R8: hold under a long stall
    send(fill(10, -10, 4, 0), {fill(1, 1, 1, 1), fill(-2, 0, 2, 0), fill(3, 3, -3, 3)}, 2'd1);
    repeat (4) idle(1'b0);
    idle(1'b1);

    for (int n = 0; n < 600; n++) begin
      logic [Q*MW-1:0] ch;
      logic [L*Q*MW-1:0] cv;
      ch = Q*MW'($urandom());
      cv = {$urandom(), $urandom(), $urandom()};
      send(ch, cv, LSW'($urandom_range(0, 3)));
      if ($urandom_range(0, 7) == 0) idle($urandom_range(0, 1) != 0);
    end
    repeat (6) idle(1'b1);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule